// File: doc/BRIEF.md
# Auxiliary Serial Port Register Front End

This block is the software-visible face of a simplified auxiliary serial port. A processor reaches it over a plain 32-bit register bus with a select, a write flag and a byte offset. Bytes that arrive from a receiver are pushed in on a valid/ready stream and kept in a small circular receive queue. Software pops them by reading the data register. A byte written to the data register leaves at once on a transmit stream, with no buffering. Because of that, the transmitter always reports idle and empty.

A single interrupt line combines two sources. The receive source is active when its enable is set and the queue holds data. The transmit source is active whenever its enable is set. A status register reports which source is active, and other status words show the queue fill level inside an otherwise fixed pattern. Line control, modem control, modem status, scratch and baud registers are present only as placeholders: they read zero and ignore writes. Serial bit timing lies outside this block.

Top module: `serport_regs`

## Requirements
- R1: After reset the interrupt enables are 0, the receive queue is empty, `irq` is low, `rx_ready` is high, `tx_valid` is low and `bus_rdata` is 0.
- R2: A write to the enable register (offset 0x44) stores only wdata bits 1:0, where bit 0 enables the receive source and bit 1 the transmit source. A read of that register returns 0xC0 ORed with the stored bits.
- R3: `irq` is high when the transmit enable is set, or when the receive enable is set and the queue is not empty. Offset 0x00 reads 1 in that case and 0 otherwise. `irq` follows any change in the cycle after the edge that causes it.
- R4: A read of the identify register (offset 0x48) returns 0xC0 | (queue not empty ? 0x4 : 0x2) | (irq low ? 0x1 : 0). The receive code wins over the transmit code.
- R5: A write to offset 0x48 with wdata bit 1 set empties the queue. If a byte is accepted in the same cycle, it becomes the only entry. A write with bit 1 clear changes nothing.
- R6: A read of the data register (offset 0x40) returns the byte at the queue head in bits 7:0 and removes it. Bytes come out in arrival order. If the queue is empty, the read returns the byte last stored in the head slot and changes nothing.
- R7: `rx_ready` is high exactly while fewer than DEPTH (8) bytes are queued. An accepted byte goes to slot (head + count) mod DEPTH. A byte offered while the queue is full is not taken.
- R8: Offset 0x54 reads 0x60 with bit 0 set when the queue is not empty. Offset 0x60 always reads 0x3. Offset 0x04 always reads 0x1.
- R9: Offset 0x64 reads 0x30E. When the queue is not empty, bit 0 is also set and the fill count appears in bits 19:16.
- R10: A write to offset 0x40 raises `tx_valid` for one cycle in the next cycle, with `tx_data` equal to wdata bits 7:0.
- R11: Offsets 0x4C, 0x50, 0x58, 0x5C and 0x68, and any unlisted offset, read as 0. Writes to them change neither the enables nor the queue.
- R12: Read data appears on `bus_rdata` in the cycle after the read strobe and reflects the state before that access. `bus_rdata` holds its value while no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Queue can take a byte |
| tx_valid | output | 1 | Transmit byte present, one-cycle pulse |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Combined interrupt |

## Verification
The bench fills the queue to DEPTH and offers a ninth byte. A design that accepted it would overwrite the head slot and return the wrong byte first. It also reads the data register on an empty queue. A design that moved the head there would lose the next byte or return a byte that is not the stale slot content. Flushes are driven both alone and together with an incoming byte, and wrong handling shows up as a count that is off by one in the status words. Random traffic mixes pops with same-cycle pushes across the wrap point and toggles the enables while the queue is empty, so an identify code that ignores priority or the pending state gives wrong read values.

// File: rtl/serport_pkg.sv
// Package: register offsets, source bit positions and the register selector
// shared by the decoder and the top of the auxiliary serial port front end.
package serport_pkg;

    localparam logic [7:0] OFF_IRQ   = 8'h00;
    localparam logic [7:0] OFF_EN    = 8'h04;
    localparam logic [7:0] OFF_IO    = 8'h40;
    localparam logic [7:0] OFF_IER   = 8'h44;
    localparam logic [7:0] OFF_IIR   = 8'h48;
    localparam logic [7:0] OFF_LSR   = 8'h54;
    localparam logic [7:0] OFF_CNTL  = 8'h60;
    localparam logic [7:0] OFF_STAT  = 8'h64;

    localparam int SRC_RX = 0;
    localparam int SRC_TX = 1;
    localparam int STAT_CNT_LSB = 16;

    typedef enum logic [3:0] {
        SEL_IRQ, SEL_EN, SEL_IO, SEL_IER, SEL_IIR,
        SEL_LSR, SEL_CNTL, SEL_STAT, SEL_NONE
    } reg_sel_e;

endpackage

// File: rtl/serport_rxq.sv
// Module: serport_rxq
// Circular receive queue with a head pointer and a fill count.
// Assumes: pop and flush never arrive in the same cycle (one bus access per
// cycle). A push during a flush lands in the head slot as the only entry.
module serport_rxq #(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    input  logic [7:0]       push_data,
    output logic             push_ready,
    input  logic             pop,
    input  logic             flush,
    output logic [7:0]       head_byte,
    output logic [CNT_W-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int SUM_W = CNT_W + 1;

    logic [7:0]       store_q [DEPTH];
    logic [PTR_W-1:0] head_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;
    logic [CNT_W-1:0] base_cnt;
    logic [SUM_W-1:0] slot_sum;
    logic [PTR_W-1:0] tail_slot;
    logic [DEPTH-1:0] slot_we;

    assign push_ready = cnt_q < CNT_W'(DEPTH);
    assign do_push    = push_valid && push_ready;
    assign do_pop     = pop && (cnt_q != '0) && !flush;
    assign base_cnt   = flush ? '0 : cnt_q;

    // Slot for an incoming byte: head plus count, wrapped at DEPTH.
    always_comb begin
        slot_sum = SUM_W'(head_q) + SUM_W'(base_cnt);
        if (slot_sum >= SUM_W'(DEPTH))
            slot_sum = slot_sum - SUM_W'(DEPTH);
        tail_slot = PTR_W'(slot_sum);
    end

    // One write enable per slot.
    for (genvar i = 0; i < DEPTH; i++) begin : g_we
        assign slot_we[i] = do_push && (tail_slot == PTR_W'(i));
    end

    // Slot storage, cleared at reset so stale reads are defined.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n)          store_q[i] <= '0;
            else if (slot_we[i]) store_q[i] <= push_data;
        end
    end

    // Head pointer: advances on each real pop, wraps at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n)
            head_q <= '0;
        else if (do_pop)
            head_q <= (head_q == PTR_W'(DEPTH - 1)) ? '0 : head_q + 1'b1;
    end

    // Fill count: flush restarts from zero, otherwise push minus pop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (flush)
            cnt_q <= do_push ? CNT_W'(1) : '0;
        else
            cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end

    assign head_byte = store_q[head_q];
    assign count     = cnt_q;

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));
    a_r7_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_W'(DEPTH) && !pop && !flush) |=> cnt_q == CNT_W'(DEPTH));
    a_r6_pop_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !flush && cnt_q != '0 && !push_valid) |=> cnt_q == $past(cnt_q) - 1'b1);
    a_r5_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !push_valid) |=> cnt_q == '0);
endmodule

// File: rtl/serport_irq.sv
// Module: serport_irq
// Holds the two interrupt enables and forms the pending bits and the line.
// Assumes: rx_nonempty comes straight from the queue count register.
module serport_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_wr,
    input  logic [1:0] en_wdata,
    input  logic       rx_nonempty,
    output logic [1:0] enables,
    output logic [1:0] pending,
    output logic       irq
);
    import serport_pkg::*;

    logic [1:0] en_q;

    // Enable register: only the two source bits are kept.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_wr) en_q <= en_wdata;
    end

    // Pending sources: receive needs data, transmit is always drained.
    always_comb begin
        pending         = '0;
        pending[SRC_RX] = en_q[SRC_RX] && rx_nonempty;
        pending[SRC_TX] = en_q[SRC_TX];
    end

    assign enables = en_q;
    assign irq     = |pending;

    a_r3_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == 2'b00) |-> !irq);
    a_r3_enable_write_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && en_wdata[SRC_TX]) |=> irq);
endmodule

// File: rtl/serport_decode.sv
// Module: serport_decode
// Turns one bus access into a register selector and side-effect strobes.
// Assumes: offsets are byte addresses of 32-bit words; unlisted ones map to SEL_NONE.
module serport_decode #(
    parameter int ADDR_W = 8
) (
    input  logic                     sel,
    input  logic                     wr,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     wbit1,
    output serport_pkg::reg_sel_e    reg_sel,
    output logic                     rd_io,
    output logic                     wr_io,
    output logic                     wr_ier,
    output logic                     flush
);
    import serport_pkg::*;

    // Offset to register selector.
    always_comb begin
        unique case (addr)
            ADDR_W'(OFF_IRQ):  reg_sel = SEL_IRQ;
            ADDR_W'(OFF_EN):   reg_sel = SEL_EN;
            ADDR_W'(OFF_IO):   reg_sel = SEL_IO;
            ADDR_W'(OFF_IER):  reg_sel = SEL_IER;
            ADDR_W'(OFF_IIR):  reg_sel = SEL_IIR;
            ADDR_W'(OFF_LSR):  reg_sel = SEL_LSR;
            ADDR_W'(OFF_CNTL): reg_sel = SEL_CNTL;
            ADDR_W'(OFF_STAT): reg_sel = SEL_STAT;
            default:           reg_sel = SEL_NONE;
        endcase
    end

    assign rd_io  = sel && !wr && (reg_sel == SEL_IO);
    assign wr_io  = sel &&  wr && (reg_sel == SEL_IO);
    assign wr_ier = sel &&  wr && (reg_sel == SEL_IER);
    assign flush  = sel &&  wr && (reg_sel == SEL_IIR) && wbit1;
endmodule

// File: rtl/serport_regs.sv
// Module: serport_regs
// Register front end of a simplified auxiliary serial port: decode, receive
// queue, interrupt logic, registered read mux and unbuffered transmit.
// Assumes: at most one bus access per cycle; read data is valid the cycle
// after the strobe and reflects the state before the access.
module serport_regs #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              irq
);
    import serport_pkg::*;

    localparam int CNT_W = $clog2(DEPTH + 1);

    reg_sel_e         reg_sel;
    logic             rd_io, wr_io, wr_ier, flush;
    logic [7:0]       head_byte;
    logic [CNT_W-1:0] count;
    logic             nonempty;
    logic [1:0]       enables, pending;
    logic [31:0]      read_val;
    logic [31:0]      rdata_q;
    logic             tx_valid_q;
    logic [7:0]       tx_data_q;
    logic             unused_wdata;

    assign unused_wdata = ^{bus_wdata[31:8], pending};

    serport_decode #(.ADDR_W(ADDR_W)) u_dec (
        .sel(bus_sel), .wr(bus_wr), .addr(bus_addr), .wbit1(bus_wdata[1]),
        .reg_sel(reg_sel), .rd_io(rd_io), .wr_io(wr_io), .wr_ier(wr_ier),
        .flush(flush)
    );

    serport_rxq #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push_valid(rx_valid), .push_data(rx_data),
        .push_ready(rx_ready), .pop(rd_io), .flush(flush),
        .head_byte(head_byte), .count(count)
    );

    assign nonempty = (count != '0);

    serport_irq u_irq (
        .clk(clk), .rst_n(rst_n), .en_wr(wr_ier), .en_wdata(bus_wdata[1:0]),
        .rx_nonempty(nonempty), .enables(enables), .pending(pending), .irq(irq)
    );

    // Read value of the selected register from the pre-access state.
    always_comb begin
        read_val = '0;
        case (reg_sel)
            SEL_IRQ:  read_val = {31'b0, irq};
            SEL_EN:   read_val = 32'h1;
            SEL_IO:   read_val = {24'b0, head_byte};
            SEL_IER:  read_val = {24'b0, 8'hC0 | {6'b0, enables}};
            SEL_IIR:  read_val = {24'b0, 8'hC0 | (nonempty ? 8'h4 : 8'h2) | {7'b0, !irq}};
            SEL_LSR:  read_val = {24'b0, 8'h60 | {7'b0, nonempty}};
            SEL_CNTL: read_val = 32'h3;
            SEL_STAT: read_val = 32'h30E | {31'b0, nonempty}
                                 | (32'(count) << STAT_CNT_LSB);
            default:  read_val = '0;
        endcase
    end

    // Read data register: captures on a read, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                rdata_q <= '0;
        else if (bus_sel && !bus_wr) rdata_q <= read_val;
    end

    // Transmit stage: one-cycle pulse carrying the written low byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid_q <= 1'b0;
            tx_data_q  <= '0;
        end else begin
            tx_valid_q <= wr_io;
            if (wr_io) tx_data_q <= bus_wdata[7:0];
        end
    end

    assign bus_rdata = rdata_q;
    assign tx_valid  = tx_valid_q;
    assign tx_data   = tx_data_q;

    a_r10_tx_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(bus_sel && bus_wr && bus_addr == ADDR_W'(OFF_IO)));
    a_r2_ier_read_form: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == ADDR_W'(OFF_IER))
        |=> (bus_rdata[31:8] == '0 && bus_rdata[7:6] == 2'b11 && bus_rdata[5:2] == '0));
    a_r12_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> $stable(bus_rdata));
    a_r7_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !nonempty |-> rx_ready);
endmodule

// File: tb/serport_regs_test.sv
// Bench for serport_regs: directed corner cases then seeded random traffic,
// checked against a bench model built from the requirements.
module serport_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready, tx_valid, irq;
    logic [7:0]  tx_data;

    int nchk = 0, nerr = 0;
    bit done = 1'b0;

    // Bench model state
    logic [7:0] m_store [8];
    int         m_head = 0, m_cnt = 0;
    logic [1:0] m_en = 2'b00;

    always #4 clk = ~clk;

    serport_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit m_irq();
        return m_en[1] || (m_en[0] && m_cnt != 0);
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h00: return {31'b0, m_irq()};
            8'h04: return 32'h1;
            8'h40: return {24'b0, m_store[m_head]};
            8'h44: return 32'hC0 | {30'b0, m_en};
            8'h48: return 32'hC0 | (m_cnt != 0 ? 32'h4 : 32'h2) | (m_irq() ? 32'h0 : 32'h1);
            8'h54: return 32'h60 | (m_cnt != 0 ? 32'h1 : 32'h0);
            8'h60: return 32'h3;
            8'h64: return 32'h30E | (m_cnt != 0 ? 32'h1 | (32'(m_cnt) << 16) : 32'h0);
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h00: return "R3";
            8'h04, 8'h54, 8'h60: return "R8";
            8'h40: return "R6";
            8'h44: return "R2";
            8'h48: return "R4";
            8'h64: return "R9";
            default: return "R11";
        endcase
    endfunction

    // One cycle: drive at a falling edge, update the model, check at the next.
    task automatic step(input bit s, input bit w, input logic [7:0] a,
                        input logic [31:0] wd, input bit rv, input logic [7:0] rd);
        logic [31:0] exp_rd, prev_rd;
        bit acc, rd_op;
        int slot;
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = wd;
        rx_valid = rv; rx_data = rd;
        rd_op   = s && !w;
        exp_rd  = m_read(a);
        prev_rd = bus_rdata;
        #1 chk("R7 rx_ready", {31'b0, rx_ready}, {31'b0, m_cnt < 8});
        acc = rv && (m_cnt < 8);
        if (s && w && a == 8'h48 && wd[1]) begin
            m_cnt = 0;
            if (acc) begin m_store[m_head] = rd; m_cnt = 1; end
        end else begin
            if (acc) begin
                slot = (m_head + m_cnt) % 8;
                m_store[slot] = rd;
            end
            if (rd_op && a == 8'h40 && m_cnt > 0) begin
                m_head = (m_head + 1) % 8;
                m_cnt--;
            end
            if (acc) m_cnt++;
        end
        if (s && w && a == 8'h44) m_en = wd[1:0];
        @(posedge clk);
        @(negedge clk);
        if (rd_op) chk({tag_of(a), " read R12"}, bus_rdata, exp_rd);
        else       chk("R12 rdata hold", bus_rdata, prev_rd);
        chk("R3 irq", {31'b0, irq}, {31'b0, m_irq()});
        chk("R10 tx_valid", {31'b0, tx_valid}, {31'b0, s && w && a == 8'h40});
        if (s && w && a == 8'h40) chk("R10 tx_data", {24'b0, tx_data}, {24'b0, wd[7:0]});
        bus_sel = 1'b0; rx_valid = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a);
        step(1, 0, a, 0, 0, 0);
    endtask
    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        step(1, 1, a, d, 0, 0);
    endtask
    task automatic push(input logic [7:0] d);
        step(0, 0, 0, 0, 1, d);
    endtask

    initial begin
        logic [7:0] addrs [16];
        addrs = '{8'h00, 8'h04, 8'h40, 8'h40, 8'h40, 8'h44, 8'h48, 8'h4C,
                  8'h50, 8'h54, 8'h58, 8'h5C, 8'h60, 8'h64, 8'h68, 8'h41};
        for (int i = 0; i < 8; i++) m_store[i] = 8'h00;
        void'($urandom(32'h5EED_0001));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rdata", bus_rdata, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 rx_ready", {31'b0, rx_ready}, 32'h1);
        chk("R1 tx_valid", {31'b0, tx_valid}, 32'h0);
        rd_reg(8'h44);
        rd_reg(8'h48);
        // R2 mask and R4 transmit code
        wr_reg(8'h44, 32'hFFFF_FFFE);
        rd_reg(8'h44);
        rd_reg(8'h48);
        wr_reg(8'h44, 32'h0000_0001);
        // R7 fill to full, offer a ninth byte
        for (int i = 0; i < 8; i++) push(8'hA0 + 8'(i));
        push(8'hEE);
        rd_reg(8'h64);
        rd_reg(8'h54);
        rd_reg(8'h48);
        // R6 drain in order, then stale read on empty
        for (int i = 0; i < 8; i++) rd_reg(8'h40);
        rd_reg(8'h40);
        rd_reg(8'h64);
        // R5 flush alone, flush with same-cycle byte, write without bit 1
        push(8'h11); push(8'h22);
        wr_reg(8'h48, 32'h1);
        rd_reg(8'h64);
        wr_reg(8'h48, 32'h2);
        rd_reg(8'h64);
        push(8'h33);
        step(1, 1, 8'h48, 32'h6, 1, 8'h44);
        rd_reg(8'h64);
        rd_reg(8'h40);
        // R11 placeholder writes leave enables and queue untouched
        push(8'h55);
        wr_reg(8'h4C, 32'hFFFF_FFFF);
        wr_reg(8'h5C, 32'hFFFF_FFFF);
        wr_reg(8'h68, 32'h3);
        rd_reg(8'h5C);
        rd_reg(8'h44);
        rd_reg(8'h64);
        // R10 transmit
        wr_reg(8'h40, 32'h1234_56C3);
        rd_reg(8'h00); rd_reg(8'h04); rd_reg(8'h60);
        // Seeded random traffic
        for (int n = 0; n < 4000; n++) begin
            int  k;
            bit  s, w, rv;
            logic [7:0] a;
            logic [31:0] wd;
            k  = int'($urandom % 16);
            a  = addrs[k];
            s  = ($urandom % 4) != 0;
            w  = ($urandom % 3) == 0;
            wd = $urandom;
            if (a == 8'h48 && w && ($urandom % 4) != 0) wd[1] = 1'b0;
            rv = ($urandom % 2) == 0;
            step(s, w, a, wd, rv, 8'($urandom));
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule